// File: doc/BRIEF.md
# DDR Serial Converter Sample Deserializer

This block takes one serial lane from a 12-bit data converter that launches a new bit on every edge of a fast bit clock, and turns it into parallel samples in the frame clock domain. The frame clock runs at the sample rate and the bit clock at six times that rate, so one frame period carries exactly twelve bits. Bits captured on rising bit-clock edges go into one 6-bit shift register and bits captured on falling edges into another. At each frame boundary the two halves are merged into one word, parked in a small ring of slots, and read out in the frame domain with a one-cycle valid strobe.

A second input path accepts 6-bit nibbles at twice the sample rate directly in the frame domain. The nibble present at the falling frame-clock edge becomes the upper half of the word, and the nibble present at the following rising edge becomes the lower half. A select input, changed only while reset is held, picks which path drives the output.

Top module: `dsr_ddr_deser`

## Requirements
- R1: While `rst_n` is low at a rising edge of either clock, the registers of that clock domain clear; after each rising frame-clock edge that sees `rst_n` low, `smp_out` is 0 and `smp_vld` is 0.
- R2: Serial bits arrive MSB first. The bit sampled on a rising bit-clock edge fills an odd bit position of the word (11, 9, ..., 1) and the bit sampled on the following falling edge fills the next lower even position (10, 8, ..., 0).
- R3: A frame boundary is the first rising bit-clock edge at which `clk_frm` is sampled high after being sampled low on the previous rising edge; the bit sampled at that edge is bit 11 of a new sample.
- R4: After reset release, the first word delivered is the sample whose bit 11 arrives at the first boundary after release; the partial frame in flight during release is never delivered.
- R5: In serial mode, a sample whose boundary follows frame-clock rising edge F(n) is presented on `smp_out` with `smp_vld` high in the frame cycle that starts at F(n+4), for exactly one frame cycle per sample.
- R6: In any frame cycle with no new word, `smp_vld` is low, and in serial mode `smp_out` keeps the last delivered word (0 after reset).
- R7: The boundary index crosses into the frame domain as a 2-bit Gray count that changes by at most one bit per bit-clock edge and only while `clk_frm` is high.
- R8: With `sel_nib` = 1, `nib_in` sampled at a falling frame-clock edge forms bits 11..6 and `nib_in` sampled at the next rising edge forms bits 5..0; the word is registered at that rising edge with `smp_vld` high.
- R9: With `sel_nib` = 1, `smp_vld` stays low after reset until a falling frame-clock edge with `rst_n` high has captured an upper nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Fast bit clock; data is sampled on both edges |
| clk_frm | input | 1 | Frame clock at the sample rate, rising at the start of each sample |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| ser_in | input | 1 | Serial data lane, one bit per bit-clock edge |
| sel_nib | input | 1 | 0: serial path drives the output; 1: nibble path drives it |
| nib_in | input | 6 | Nibble input at twice the sample rate, upper nibble first |
| smp_out | output | 12 | Reconstructed sample, frame clock domain |
| smp_vld | output | 1 | One frame cycle high for each new sample |

## Verification
Serial samples are mostly random, with all-zeros and all-ones words to catch stuck or missing capture, 0xAAA and 0x555 whose alternating bits expose a swap between the rising-edge and falling-edge registers, and 0x800 and 0x001 which isolate the MSB-first order and reveal a word shifted by one bit or one frame. Reset is applied in the middle of a running stream, so the cycle-accurate reference shows whether a partial frame leaks out and whether the first word after release lands in the right frame. The nibble path runs with random pairs, which separates upper from lower half ordering and checks that the nibble word appears in the same frame cycle as its second half.

// File: rtl/dsr_pkg.sv
// Shared constants, types and helpers for the DDR sample deserializer.
// Assumes the slot ring is a power of two deep so the Gray count wraps cleanly.
package dsr_pkg;
    localparam int PTR_W = 2;
    localparam int SLOTS = 1 << PTR_W;

    typedef logic [PTR_W-1:0] ptr_t;

    // Binary to Gray conversion of a slot pointer.
    function automatic ptr_t to_gray(input ptr_t bin);
        return bin ^ (bin >> 1);
    endfunction
endpackage

// File: rtl/dsr_edge_capture.sv
// Two half-width shift registers on opposite bit-clock edges.
// The rising-edge register collects odd-position bits, the falling-edge one
// even-position bits; index 0 always holds the most recent bit.
// Assumes ser_in is stable around both edges of clk_bit.
module dsr_edge_capture #(
    parameter int HALF_W = 6
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [HALF_W-1:0] rise_sh,
    output logic [HALF_W-1:0] fall_sh
);

    // Shift in the bit present at each rising edge.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) rise_sh <= '0;
        else        rise_sh <= {rise_sh[HALF_W-2:0], ser_in};
    end

    // Shift in the bit present at each falling edge.
    always_ff @(negedge clk_bit) begin
        if (!rst_n) fall_sh <= '0;
        else        fall_sh <= {fall_sh[HALF_W-2:0], ser_in};
    end

endmodule

// File: rtl/dsr_frame_latch.sv
// Bit-domain frame handling: spots the frame boundary by sampling the frame
// clock level, interleaves the two shift registers into a word and writes it
// into a ring of slots, publishing the write index as a registered Gray count.
// Assumes clk_frm changes well away from rising edges of clk_bit.
module dsr_frame_latch
    import dsr_pkg::*;
#(
    parameter  int HALF_W = 6,
    localparam int SMP_W  = 2 * HALF_W
) (
    input  logic                        clk_bit,
    input  logic                        rst_n,
    input  logic                        frm_lvl,
    input  logic [HALF_W-1:0]           rise_sh,
    input  logic [HALF_W-1:0]           fall_sh,
    output ptr_t                        wr_gray,
    output logic [SLOTS-1:0][SMP_W-1:0] slot_q
);

    logic             frm_s;
    logic             armed;
    logic             bnd;
    ptr_t             wr_bin;
    logic [SMP_W-1:0] word;

    // Interleave: rising-edge bits take odd positions, falling-edge bits even.
    for (genvar i = 0; i < HALF_W; i++) begin : g_ilv
        assign word[2*i+1] = rise_sh[i];
        assign word[2*i]   = fall_sh[i];
    end

    // A boundary is the edge that sees the frame clock high after a low sample.
    assign bnd = frm_lvl & ~frm_s;

    // Remember the frame clock level seen at the previous rising edge.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) frm_s <= 1'b1;
        else        frm_s <= frm_lvl;
    end

    // Arm after the first boundary so only complete frames are stored.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)   armed <= 1'b0;
        else if (bnd) armed <= 1'b1;
    end

    // Store the finished word and advance the write index.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            wr_bin <= '0;
            slot_q <= '0;
        end else if (bnd && armed) begin
            slot_q[wr_bin] <= word;
            wr_bin         <= wr_bin + 1'b1;
        end
    end

    // Publish the write index in Gray code from a register.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) wr_gray <= '0;
        else        wr_gray <= to_gray(wr_bin);
    end

endmodule

// File: rtl/dsr_frame_out.sv
// Frame-domain output: synchronizes the Gray write index through two stages,
// reads one slot per new index, and alternatively assembles words from
// nibbles arriving on both frame-clock edges.
// Assumes a slot is not rewritten until four boundaries after it was filled.
module dsr_frame_out
    import dsr_pkg::*;
#(
    parameter  int HALF_W = 6,
    localparam int SMP_W  = 2 * HALF_W
) (
    input  logic                        clk_frm,
    input  logic                        rst_n,
    input  logic                        sel_nib,
    input  logic [HALF_W-1:0]           nib_in,
    input  ptr_t                        wr_gray,
    input  logic [SLOTS-1:0][SMP_W-1:0] slot_q,
    output logic [SMP_W-1:0]            smp_out,
    output logic                        smp_vld
);

    ptr_t              sync1;
    ptr_t              sync2;
    ptr_t              rd_bin;
    logic              fresh;
    logic [HALF_W-1:0] nib_hi;
    logic              nib_ok;

    assign fresh = (to_gray(rd_bin) != sync2);

    // Two-stage synchronizer for the Gray write index.
    always_ff @(posedge clk_frm) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= wr_gray;
            sync2 <= sync1;
        end
    end

    // Step the read index once for every word that has crossed.
    always_ff @(posedge clk_frm) begin
        if (!rst_n)     rd_bin <= '0;
        else if (fresh) rd_bin <= rd_bin + 1'b1;
    end

    // Hold the upper nibble presented at the falling frame edge.
    always_ff @(negedge clk_frm) begin
        if (!rst_n) begin
            nib_hi <= '0;
            nib_ok <= 1'b0;
        end else begin
            nib_hi <= nib_in;
            nib_ok <= 1'b1;
        end
    end

    // Drive the output word and its strobe from the selected path.
    always_ff @(posedge clk_frm) begin
        if (!rst_n) begin
            smp_out <= '0;
            smp_vld <= 1'b0;
        end else if (sel_nib) begin
            smp_out <= {nib_hi, nib_in};
            smp_vld <= nib_ok;
        end else if (fresh) begin
            smp_out <= slot_q[rd_bin];
            smp_vld <= 1'b1;
        end else begin
            smp_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/dsr_ddr_deser.sv
// Top of the DDR serial sample deserializer: edge capture and frame latch in
// the bit clock domain, read-out and nibble assembly in the frame domain.
// Assumes SMP_W is even, the bit clock runs at SMP_W/2 times the frame clock,
// and sel_nib changes only while rst_n is low.
module dsr_ddr_deser
    import dsr_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input  logic               clk_bit,
    input  logic               clk_frm,
    input  logic               rst_n,
    input  logic               ser_in,
    input  logic               sel_nib,
    input  logic [SMP_W/2-1:0] nib_in,
    output logic [SMP_W-1:0]   smp_out,
    output logic               smp_vld
);

    localparam int HALF_W = SMP_W / 2;

    logic [HALF_W-1:0]           rise_sh;
    logic [HALF_W-1:0]           fall_sh;
    ptr_t                        wr_gray;
    logic [SLOTS-1:0][SMP_W-1:0] slot_q;

    dsr_edge_capture #(.HALF_W(HALF_W)) u_cap (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .rise_sh (rise_sh),
        .fall_sh (fall_sh)
    );

    dsr_frame_latch #(.HALF_W(HALF_W)) u_latch (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .frm_lvl (clk_frm),
        .rise_sh (rise_sh),
        .fall_sh (fall_sh),
        .wr_gray (wr_gray),
        .slot_q  (slot_q)
    );

    dsr_frame_out #(.HALF_W(HALF_W)) u_out (
        .clk_frm (clk_frm),
        .rst_n   (rst_n),
        .sel_nib (sel_nib),
        .nib_in  (nib_in),
        .wr_gray (wr_gray),
        .slot_q  (slot_q),
        .smp_out (smp_out),
        .smp_vld (smp_vld)
    );

endmodule

// File: rtl/dsr_ddr_deser_chk.sv
// Property checker for the DDR sample deserializer, bound to its top.
// Observes ports and the Gray index that links the two clock domains.
module dsr_ddr_deser_chk
    import dsr_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input logic               clk_bit,
    input logic               clk_frm,
    input logic               rst_n,
    input logic               sel_nib,
    input logic [SMP_W/2-1:0] nib_in,
    input logic [SMP_W-1:0]   smp_out,
    input logic               smp_vld,
    input ptr_t               wr_gray
);

    // R1: the frame cycle after a reset edge shows a cleared output.
    a_r1_reset_clears: assert property (@(posedge clk_frm) disable iff (!rst_n)
        $past(!rst_n) |-> (!smp_vld && smp_out == '0));

    // R7: the crossing index moves by at most one bit per bit-clock edge.
    a_r7_gray_single_step: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R7, R3: the index only moves in the high phase that follows a boundary.
    a_r7_move_in_high_phase: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (wr_gray != $past(wr_gray)) |-> clk_frm);

    // R8: a valid nibble word carries the nibble seen at its rising edge.
    a_r8_low_half_from_edge: assert property (@(posedge clk_frm) disable iff (!rst_n)
        ($past(sel_nib) && smp_vld) |-> (smp_out[SMP_W/2-1:0] == $past(nib_in)));

    // R6: in serial mode a cycle without a word leaves the output untouched.
    a_r6_hold_when_idle: assert property (@(posedge clk_frm) disable iff (!rst_n)
        (!$past(sel_nib) && $past(rst_n) && !smp_vld) |-> $stable(smp_out));

endmodule

bind dsr_ddr_deser dsr_ddr_deser_chk #(.SMP_W(SMP_W)) u_chk (.*);

// File: tb/sim_dsr_ddr_deser.sv
// Cycle-accurate reference bench: drives DDR serial frames and nibble pairs,
// predicts each output frame cycle from a queue of due words, compares on
// every falling frame-clock edge.
module sim_dsr_ddr_deser;

    localparam int CLK_PERIOD = 8;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int SMP_W      = 12;
    localparam int NW         = SMP_W / 2;
    localparam int SER_LAT    = 4;
    localparam int NIB_LAT    = 1;
    localparam int LAST_FRAME = 260;

    logic             clk_bit = 1'b0;
    logic             clk_frm = 1'b0;
    logic             rst_n   = 1'b0;
    logic             ser_in  = 1'b0;
    logic             sel_nib = 1'b0;
    logic [NW-1:0]    nib_in  = '0;
    logic [SMP_W-1:0] smp_out;
    logic             smp_vld;

    typedef struct {
        int               due;
        logic [SMP_W-1:0] d;
        bit               nib;
        bit               first;
    } exp_t;

    exp_t             q[$];
    int               n_tests    = 0;
    int               n_fail     = 0;
    int               frm_idx    = -1;
    int               n_ser      = 0;
    int               n_nib      = 0;
    bit               need_first = 1'b1;
    bit               rst_at_pos = 1'b0;
    bit               rst_b6     = 1'b0;
    logic [SMP_W-1:0] cur        = '0;
    logic [SMP_W-1:0] last_out   = '0;
    logic [NW-1:0]    hi_v       = '0;
    logic [NW-1:0]    lo_v       = '0;

    dsr_ddr_deser #(.SMP_W(SMP_W)) u0 (
        .clk_bit (clk_bit),
        .clk_frm (clk_frm),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .sel_nib (sel_nib),
        .nib_in  (nib_in),
        .smp_out (smp_out),
        .smp_vld (smp_vld)
    );

    // Directed words: stuck bits, edge swap, bit order.
    function automatic logic [SMP_W-1:0] pick(input int f);
        case ((f / 5) % 6)
            0:       return 12'h000;
            1:       return 12'hFFF;
            2:       return 12'hAAA;
            3:       return 12'h555;
            4:       return 12'h800;
            default: return 12'h001;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s frame %0d: actual %h expected %h", tag, frm_idx, act, exp);
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Stimulus: one frame per outer pass, one bit-clock edge per inner pass.
    initial begin
        for (int f = 0; f < LAST_FRAME; f++) begin
            for (int b = 0; b < 2 * NW; b++) begin
                #(HALF - 2);
                if (b == 0) begin
                    frm_idx = f;
                    cur = (f % 5 == 0) ? pick(f) : SMP_W'($urandom);
                    if (rst_n && !sel_nib) begin
                        q.push_back('{f + SER_LAT, cur, 1'b0, need_first});
                        need_first = 1'b0;
                    end
                    clk_frm = 1'b1;
                end
                if (b == NW) begin
                    clk_frm = 1'b0;
                    rst_b6  = rst_n;
                end
                ser_in = cur[2*NW-1-b];
                if (b == 1 && (f == 3 || f == 123 || f == 173)) rst_n = 1'b1;
                if (b == 2 && f == 121) sel_nib = 1'b1;
                if (b == 2 && f == 171) sel_nib = 1'b0;
                if (b == NW + 1 && (f == 120 || f == 170)) begin
                    rst_n = 1'b0;
                    q.delete();
                    need_first = 1'b1;
                end
                if (b == NW / 2) begin
                    hi_v   = NW'($urandom);
                    nib_in = hi_v;
                end
                if (b == NW + NW / 2) begin
                    lo_v   = NW'($urandom);
                    nib_in = lo_v;
                    if (rst_n && rst_b6 && sel_nib) begin
                        q.push_back('{f + NIB_LAT, {hi_v, lo_v}, 1'b1, need_first});
                        need_first = 1'b0;
                    end
                end
                #2 clk_bit = ~clk_bit;
            end
        end
        check(n_ser >= 180, "R2", n_ser, 180);
        check(n_nib >= 40, "R8", n_nib, 40);
        summary();
        $finish;
    end

    // Reset as seen by the frame domain at its rising edge.
    always @(posedge clk_frm) rst_at_pos <= rst_n;

    // Reference comparison once per frame cycle, away from the active edge.
    always @(negedge clk_frm) begin
        if (!rst_at_pos) begin
            check(smp_vld == 1'b0, "R1", smp_vld, 0);
            check(smp_out == '0, "R1", smp_out, 0);
            last_out = '0;
        end else begin
            while (q.size() > 0 && q[0].due < frm_idx) begin
                check(1'b0, "R5", 0, q[0].d);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].due == frm_idx) begin
                exp_t e;
                e = q.pop_front();
                if (e.nib) begin
                    check(smp_vld == 1'b1, "R8", smp_vld, 1);
                    check(smp_out == e.d, e.first ? "R9" : "R8", smp_out, e.d);
                    if (smp_out == e.d) n_nib++;
                end else begin
                    check(smp_vld == 1'b1, "R5", smp_vld, 1);
                    check(smp_out == e.d, e.first ? "R4" : "R2/R3", smp_out, e.d);
                    if (smp_out == e.d) n_ser++;
                end
            end else begin
                check(smp_vld == 1'b0, "R6", smp_vld, 0);
                if (!sel_nib) check(smp_out == last_out, "R6", smp_out, last_out);
            end
            if (smp_vld) last_out = smp_out;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

endmodule